// File: doc/BRIEF.md
# DRAM Strobe Cycle-Type Classifier

This block sits on the device side of an asynchronous multiplexed-address DRAM port. It samples the row strobe, column strobe, write enable and output enable (all active low) into a faster system clock. It works out what kind of memory cycle the host performed from the order in which those strobes fall. While a cycle runs it captures the row address, the column address and any write data at the right moments. It also decides when the device should drive its data pins.

When a row-strobe period ends, the block publishes a cycle-type code and a one-clock completion pulse. A storage array placed behind it can use the code, the latched addresses, the write data strobe and the output-enable decision without decoding strobe timing itself. Analog setup and hold windows are not modelled. Every strobe edge is seen only as a change between two registered samples.

Top module: `dram_cycle_classifier`

## Requirements
- R1: `row_addr` loads `addr` when the row strobe falls while the column strobe is high, and holds its value at all other times, including refresh cycles entered with the column strobe already low.
- R2: `col_addr` loads `addr[COL_W-1:0]` (the upper address bits are dropped) when the column strobe falls while the row strobe is low and the cycle is not a column-first refresh.
- R3: Early write: if write enable is already low when the column strobe falls, `wr_data` takes `din` at that column edge and `wr_stb` pulses for exactly one clock. The cycle ends with code 2.
- R4: Delayed write / read-modify-write: if write enable falls while the column strobe is low and was high at the column edge, `wr_data` takes `din` at the write-enable edge and `wr_stb` pulses once. The cycle ends with code 3. While output enable is low before that edge, read data is driven (`dout_en`=1). After output enable returns high it is not driven.
- R5: A cycle with a column edge and write enable held high ends with code 1. `dout_en` is 1 while both the column strobe and output enable are low.
- R6: Row-only refresh: a row-strobe period with no column edge ends with code 4. `col_addr` is unchanged.
- R7: Column-first refresh: if the column strobe is low when the row strobe falls and no read data is being held, the cycle ends with code 5. Both addresses are unchanged and no `wr_stb` is issued.
- R8: Hidden refresh: after a read whose data is driven, the row strobe rises and falls again with the column strobe held low. This cycle ends with code 6, and `dout_en` stays 1 throughout until the column strobe rises.
- R9: After reset `cyc_type` is 0 (standby) and `cyc_done`, `wr_stb` and `dout_en` are 0. `cyc_type` changes only together with `cyc_done`, a single-clock pulse issued one clock after a row-strobe rise is detected.
- R10: `dout_en` is 0 in standby (both strobes high), throughout an early write even with output enable low, and throughout row-only and column-first refresh cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | DATA_W | Write data from the host |
| cyc_type | output | 3 | Code of the last completed cycle: 0 standby, 1 read, 2 early write, 3 delayed write, 4 row-only refresh, 5 column-first refresh, 6 hidden refresh |
| cyc_done | output | 1 | One-clock pulse when `cyc_type` is updated |
| row_addr | output | ROW_W | Latched row address |
| col_addr | output | COL_W | Latched column address |
| wr_data | output | DATA_W | Captured write data |
| wr_stb | output | 1 | One-clock pulse when `wr_data` is captured |
| dout_en | output | 1 | Device should drive its data pins |

## Verification
The bench builds the block with ROW_W=11, COL_W=10, DATA_W=8 and SYNC_STAGES=2. Because the address bus is one bit wider than the column field, a column value with bit 10 set tests that the top bit is dropped. The short two-stage synchroniser lets each strobe phase be held for only a few clocks. In that time `din` can be changed between the column edge and the write-enable edge, which separates the two write-capture points. A read followed by a row-strobe bounce with the column strobe held low reaches the hidden-refresh path. The same column-low entry without a preceding read reaches the plain column-first refresh.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [2:0] {
        CYC_STANDBY  = 3'd0,
        CYC_READ     = 3'd1,
        CYC_EARLY_WR = 3'd2,
        CYC_LATE_WR  = 3'd3,
        CYC_ROW_REF  = 3'd4,
        CYC_COL_REF  = 3'd5,
        CYC_HIDDEN   = 3'd6
    } cyc_kind_e;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dsc_edge.sv
module dsc_edge
    import dsc_pkg::*;
#(
    parameter int WIDTH = 1,
    parameter edge_sel_e SEL = EDGE_FALL,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    generate
        if (SEL == EDGE_FALL) begin : g_fall
            assign evt = prev_q & ~lvl;
        end else begin : g_rise
            assign evt = ~prev_q & lvl;
        end
    endgenerate
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dsc_pkg::*;
#(
    parameter int ROW_W       = 11,
    parameter int COL_W       = 10,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ROW_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [2:0]        cyc_type,
    output logic              cyc_done,
    output logic [ROW_W-1:0]  row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              dout_en
);
    localparam int STB_W = 4;
    localparam int BUS_W = ROW_W + DATA_W;

    // Synchronised strobes {oe, we, cas, ras} and aligned data bus
    logic [STB_W-1:0] stb_s;
    logic [BUS_W-1:0] bus_s;

    dsc_sync #(.WIDTH(STB_W), .STAGES(SYNC_STAGES), .RST_VAL({STB_W{1'b1}})) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d({oe_n, we_n, cas_n, ras_n}), .q(stb_s)
    );
    dsc_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({addr, din}), .q(bus_s)
    );

    logic s_ras, s_cas, s_we, s_oe;
    logic [ROW_W-1:0]  s_addr;
    logic [DATA_W-1:0] s_din;
    assign {s_oe, s_we, s_cas, s_ras} = stb_s;
    assign {s_addr, s_din}            = bus_s;

    // Edge events between successive synchronised samples
    logic [2:0] fall_evt;
    logic       rise_evt;
    logic       ras_fall, cas_fall, we_fall, ras_rise;

    dsc_edge #(.WIDTH(3), .SEL(EDGE_FALL), .RST_VAL(3'b111)) u_fall (
        .clk(clk), .rst_n(rst_n), .lvl({s_we, s_cas, s_ras}), .evt(fall_evt)
    );
    dsc_edge #(.WIDTH(1), .SEL(EDGE_RISE), .RST_VAL(1'b1)) u_rise (
        .clk(clk), .rst_n(rst_n), .lvl(s_ras), .evt(rise_evt)
    );

    assign ras_fall = fall_evt[0];
    assign cas_fall = fall_evt[1];
    assign we_fall  = fall_evt[2];
    assign ras_rise = rise_evt;

    typedef struct packed {
        cyc_kind_e         kind;
        logic              done;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic              wstb;
        logic              drive;
        logic              col_first;   // column strobe low at row edge
        logic              hidden;      // column-first entry with held read data
        logic              col_seen;    // a column edge occurred this row period
        logic              early_any;
        logic              late_any;
        logic              early_cas;   // current column period is an early write
        logic              hold_out;    // read data held across a row-strobe bounce
    } cls_state_t;

    cls_state_t st_d, st_q;

    function automatic cyc_kind_e classify(input cls_state_t s);
        if (s.col_first)     return s.hidden ? CYC_HIDDEN : CYC_COL_REF;
        else if (!s.col_seen) return CYC_ROW_REF;
        else if (s.early_any) return CYC_EARLY_WR;
        else if (s.late_any)  return CYC_LATE_WR;
        else                  return CYC_READ;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wstb = 1'b0;

        if (ras_fall) begin
            st_d.col_seen  = 1'b0;
            st_d.early_any = 1'b0;
            st_d.late_any  = 1'b0;
            st_d.early_cas = 1'b0;
            if (!s_cas) begin
                st_d.col_first = 1'b1;
                st_d.hidden    = st_q.hold_out;
            end else begin
                st_d.col_first = 1'b0;
                st_d.hidden    = 1'b0;
                st_d.row       = s_addr;
            end
        end

        if (cas_fall && !s_ras && !st_d.col_first) begin
            st_d.col       = s_addr[COL_W-1:0];
            st_d.col_seen  = 1'b1;
            st_d.early_cas = !s_we;
            if (!s_we) begin
                st_d.wdata     = s_din;
                st_d.wstb      = 1'b1;
                st_d.early_any = 1'b1;
            end
        end

        if (we_fall && !cas_fall && !s_ras && !s_cas && st_d.col_seen
            && !st_d.col_first && !st_d.early_cas) begin
            st_d.wdata    = s_din;
            st_d.wstb     = 1'b1;
            st_d.late_any = 1'b1;
        end

        if (ras_rise) begin
            st_d.done = 1'b1;
            st_d.kind = classify(st_d);
        end

        if (s_cas)                         st_d.hold_out = 1'b0;
        else if (ras_rise && st_q.drive)   st_d.hold_out = 1'b1;

        st_d.drive = !s_cas && !s_oe &&
                     (st_d.hold_out ||
                      (!s_ras && st_d.col_seen && !st_d.col_first && !st_d.early_cas));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= CYC_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_type = st_q.kind;
    assign cyc_done = st_q.done;
    assign row_addr = st_q.row;
    assign col_addr = st_q.col;
    assign wr_data  = st_q.wdata;
    assign wr_stb   = st_q.wstb;
    assign dout_en  = st_q.drive;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int ROW_W = 11,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_fall,
    input logic             cas_fall,
    input logic             ras_rise,
    input logic [ROW_W-1:0] row_addr,
    input logic [COL_W-1:0] col_addr,
    input logic [2:0]       cyc_type,
    input logic             cyc_done,
    input logic             wr_stb,
    input logic             dout_en
);
    p_row_only_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_fall |=> $stable(row_addr));

    p_col_only_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_fall |=> $stable(col_addr));

    p_wstb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    p_done_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> $past(ras_rise));

    p_type_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |-> $stable(cyc_type));

    p_refresh_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && (cyc_type == 3'd4 || cyc_type == 3'd5)) |-> !dout_en);
endmodule

bind dram_cycle_classifier dsc_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_fall(ras_fall), .cas_fall(cas_fall),
    .ras_rise(ras_rise), .row_addr(row_addr), .col_addr(col_addr),
    .cyc_type(cyc_type), .cyc_done(cyc_done), .wr_stb(wr_stb), .dout_en(dout_en)
);

// File: tb/sim_dram_cycle_classifier.sv
module sim_dram_cycle_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [2:0]  cyc_type;
    logic        cyc_done, wr_stb, dout_en;
    logic [10:0] row_addr;
    logic [9:0]  col_addr;
    logic [7:0]  wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cycle_classifier u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .cyc_type(cyc_type),
        .cyc_done(cyc_done), .row_addr(row_addr), .col_addr(col_addr),
        .wr_data(wr_data), .wr_stb(wr_stb), .dout_en(dout_en)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic [10:0] row;
        logic [9:0]  col;
    } cyc_item_t;

    cyc_item_t   exp_cyc[$];
    string       exp_cyc_req[$];
    logic [7:0]  exp_wr[$];
    string       exp_wr_req[$];
    int unsigned n_cmp = 0, n_bad = 0;
    bit          finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_cyc(input string req, input logic [2:0] k,
                            input logic [10:0] r, input logic [9:0] c);
        exp_cyc.push_back('{kind: k, row: r, col: c});
        exp_cyc_req.push_back(req);
    endtask

    task automatic push_wr(input string req, input logic [7:0] d);
        exp_wr.push_back(d);
        exp_wr_req.push_back(req);
    endtask

    // Monitor: pops expected results as the design reports them
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cyc_done) begin
                if (exp_cyc.size() == 0) chk("R9 unexpected cycle", {29'd0, cyc_type}, 32'hFFFF);
                else begin
                    automatic cyc_item_t e = exp_cyc.pop_front();
                    automatic string rq = exp_cyc_req.pop_front();
                    chk({rq, " type"}, {29'd0, cyc_type}, {29'd0, e.kind});
                    chk({rq, " row (R1)"}, {21'd0, row_addr}, {21'd0, e.row});
                    chk({rq, " col (R2)"}, {22'd0, col_addr}, {22'd0, e.col});
                end
            end
            if (wr_stb) begin
                if (exp_wr.size() == 0) chk("R7 unexpected write strobe", {24'd0, wr_data}, 32'hFFFF);
                else begin
                    automatic logic [7:0] d = exp_wr.pop_front();
                    automatic string rq = exp_wr_req.pop_front();
                    chk({rq, " write data"}, {24'd0, wr_data}, {24'd0, d});
                end
            end
        end
    end

    initial begin
        int done_hits;
        step(3);
        // R9: reset state
        chk("R9 reset type", {29'd0, cyc_type}, 32'd0);
        chk("R9 reset done", {31'd0, cyc_done}, 32'd0);
        chk("R9 reset strobe", {31'd0, wr_stb}, 32'd0);
        chk("R9 reset dout", {31'd0, dout_en}, 32'd0);
        rst_n = 1'b1;
        step(4);

        // R5 read, R2 upper address bit dropped
        addr = 11'h5A3; ras_n = 1'b0; step(HOLD);
        addr = 11'h5C7; cas_n = 1'b0; oe_n = 1'b0; step(HOLD);
        chk("R5 read drives data", {31'd0, dout_en}, 32'd1);
        push_cyc("R5", 3'd1, 11'h5A3, 10'h1C7);
        oe_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1; step(HOLD);
        chk("R10 standby no drive", {31'd0, dout_en}, 32'd0);

        // R3 early write, output enable low must not drive (R10)
        addr = 11'h123; ras_n = 1'b0; step(HOLD);
        we_n = 1'b0; oe_n = 1'b0; step(2);
        addr = 11'h2AA; din = 8'h3C; cas_n = 1'b0; push_wr("R3", 8'h3C); step(HOLD);
        chk("R10 early write no drive", {31'd0, dout_en}, 32'd0);
        din = 8'h99; step(HOLD);
        push_cyc("R3", 3'd2, 11'h123, 10'h2AA);
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; step(HOLD);

        // R4 read-modify-write: data captured at write-enable edge
        addr = 11'h7FF; ras_n = 1'b0; step(HOLD);
        din = 8'h11; cas_n = 1'b0; oe_n = 1'b0; step(HOLD);
        chk("R4 read phase drives", {31'd0, dout_en}, 32'd1);
        oe_n = 1'b1; step(HOLD);
        chk("R4 oe high stops drive", {31'd0, dout_en}, 32'd0);
        din = 8'hE7; we_n = 1'b0; push_wr("R4", 8'hE7); step(HOLD);
        push_cyc("R4", 3'd3, 11'h7FF, 10'h3FF);
        cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; step(HOLD);

        // R6 row-only refresh, plus single done pulse (R9)
        addr = 11'h400; ras_n = 1'b0; step(HOLD);
        chk("R10 row refresh no drive", {31'd0, dout_en}, 32'd0);
        push_cyc("R6", 3'd4, 11'h400, 10'h3FF);
        ras_n = 1'b1;
        done_hits = 0;
        for (int i = 0; i < 12; i++) begin
            step(1);
            if (cyc_done) done_hits++;
        end
        chk("R9 done pulse count", done_hits, 32'd1);

        // R7 column-first refresh: no address change, no drive
        cas_n = 1'b0; oe_n = 1'b0; addr = 11'h0AB; step(HOLD);
        ras_n = 1'b0; step(HOLD);
        chk("R7 column-first no drive", {31'd0, dout_en}, 32'd0);
        push_cyc("R7", 3'd5, 11'h400, 10'h3FF);
        ras_n = 1'b1; step(HOLD);
        cas_n = 1'b1; oe_n = 1'b1; step(HOLD);

        // R8 hidden refresh after a driven read
        addr = 11'h2B6; ras_n = 1'b0; step(HOLD);
        addr = 11'h155; cas_n = 1'b0; oe_n = 1'b0; step(HOLD);
        push_cyc("R8 leading read", 3'd1, 11'h2B6, 10'h155);
        ras_n = 1'b1; step(HOLD);
        chk("R8 drive held, row high", {31'd0, dout_en}, 32'd1);
        addr = 11'h777; ras_n = 1'b0; step(HOLD);
        chk("R8 drive held, row low", {31'd0, dout_en}, 32'd1);
        push_cyc("R8", 3'd6, 11'h2B6, 10'h155);
        ras_n = 1'b1; step(HOLD);
        chk("R8 drive held after hidden", {31'd0, dout_en}, 32'd1);
        cas_n = 1'b1; oe_n = 1'b1; step(HOLD);
        chk("R10 standby after hidden", {31'd0, dout_en}, 32'd0);

        step(HOLD);
        chk("R9 all cycles reported", exp_cyc.size(), 32'd0);
        chk("R3 all writes reported", exp_wr.size(), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R9 watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule